// File: doc/BRIEF.md
# Beam Pickup Acquisition Sequencer

This block runs one complete capture cycle for a three-channel beam pickup front end. The three channels are the beam sum and two position differences. While idle it waits for a trigger. The trigger opens a write window on an external analog sampling memory, which records every channel at once. The block then reads that memory back one cell at a time. Each cell is digitised by a slow 14-bit converter, and every converted word goes into an on-chip sample RAM. When all samples are stored, the block raises an interrupt level to a slow-control host. It holds that level until the host asks for the data, then streams every stored sample out over a valid/ready port and returns to idle.

Conversion is paced only by the converter's done handshake. The converter runs at a few hundred kilosamples per second, so a readout can take any number of clock cycles per sample. Sample `k` of the dump is the word that converter handled for channel `k / CELLS`, cell `k % CELLS`. Back-pressure on the output stream is free: the sink may hold ready low for any number of cycles. While it does, the offered word and its last flag do not change. A word moves only in a cycle where valid and ready are both high. Valid stays high for the whole dump phase.

Top module: `capture_sequencer`

## Requirements
- R1: During and right after reset the block is idle, and every output (memory controls, address, channel, convert start, interrupt, stream valid, data and last) is 0.
- R2: A trigger sampled high while idle starts the capture phase on the next cycle. `amem_wr_o` is then high for exactly CELLS cycles, `amem_addr_o` counts 0 to CELLS-1 (one step per cycle) and `amem_ch_o` is 0.
- R3: A trigger sampled in any phase other than idle has no effect on any output.
- R4: The readout phase follows capture immediately. `amem_rd_o` stays high through it, and `amem_ch_o`/`amem_addr_o` give the sample being converted: all cells of channel 0 in rising order, then channel 1, then channel 2. At most one of `amem_wr_o`, `amem_rd_o`, `irq_o` and `out_valid_o` is high in any cycle. Address and channel are 0 outside capture and readout.
- R5: For each sample, `adc_start_o` is high for exactly one cycle: the first readout cycle of that sample. A done pulse seen in a later cycle stores the word and moves to the next sample, whose start follows on the next cycle. A done pulse in any other cycle or phase is ignored.
- R6: The 14-bit word stored for a sample is the value of `adc_data_i` in the cycle where its done is taken. It is kept at RAM address channel×CELLS+cell.
- R7: The cycle after the last sample is stored, `irq_o` goes high. It stays high for as long as `host_rd_i` is low. When a request is seen, it drops on the next cycle. A request outside this phase is ignored.
- R8: The dump phase begins the cycle after the request is seen, with `out_valid_o` high. Data is the stored words in address order. While ready is low, data and last stay unchanged.
- R9: `out_last_o` is high only with the final word (address NUM_CH×CELLS-1). When that word is accepted, the block returns to idle and valid falls on the next cycle.
- R10: Each cycle moves exactly NUM_CH×CELLS words. A trigger in idle after a finished cycle starts a fresh cycle that behaves the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Beam trigger, sampled on the clock |
| amem_wr_o | output | 1 | Analog memory write window |
| amem_rd_o | output | 1 | Analog memory readout enable |
| amem_addr_o | output | 8 | Analog memory cell index |
| amem_ch_o | output | 2 | Channel being read back |
| adc_start_o | output | 1 | One-cycle convert start |
| adc_done_i | input | 1 | Converter done pulse |
| adc_data_i | input | 14 | Converted sample, valid with done |
| irq_o | output | 1 | Data-ready interrupt level |
| host_rd_i | input | 1 | Host read request |
| out_valid_o | output | 1 | Stream word valid |
| out_ready_i | input | 1 | Stream sink ready |
| out_data_o | output | 14 | Stream sample word |
| out_last_o | output | 1 | Marks the final word of a cycle |

## Verification
The properties take for granted that trigger, done, request and ready are synchronous to the clock. They also assume the converter answers each start with a single done pulse, some cycles later. Counting and stability checks in the dump rely on the request arriving only after the interrupt has been seen. The bench's converter model answers each start once, after one to three cycles. It adds stray done pulses only during capture and while the interrupt is pending. It sends stray triggers and requests in every busy phase. A reference model of the five phases is compared with every output on every clock under three ready patterns.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_CAPTURE = 3'd1,
    PH_READOUT = 3'd2,
    PH_NOTIFY  = 3'd3,
    PH_DUMP    = 3'd4
  } phase_e;

endpackage

// File: rtl/seq_phase_ctrl.sv
module seq_phase_ctrl
  import seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   trig_i,
  input  logic   capture_last_i,
  input  logic   readout_last_i,
  input  logic   host_rd_i,
  input  logic   dump_last_i,
  output phase_e phase_o
);

  phase_e phase_q;
  phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_IDLE:    if (trig_i)         phase_d = PH_CAPTURE;
      PH_CAPTURE: if (capture_last_i) phase_d = PH_READOUT;
      PH_READOUT: if (readout_last_i) phase_d = PH_NOTIFY;
      PH_NOTIFY:  if (host_rd_i)      phase_d = PH_DUMP;
      PH_DUMP:    if (dump_last_i)    phase_d = PH_IDLE;
      default:                        phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_IDLE;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;

endmodule

// File: rtl/seq_sample_engine.sv
module seq_sample_engine
  import seq_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int CELLS    = 256,
  parameter int SAMPLE_W = 14,
  localparam int CELL_W  = $clog2(CELLS),
  localparam int TOTAL   = NUM_CH * CELLS,
  localparam int IDX_W   = $clog2(TOTAL),
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  phase_e              phase_i,
  input  logic                adc_done_i,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  output logic                amem_wr_o,
  output logic                amem_rd_o,
  output logic [CELL_W-1:0]   amem_addr_o,
  output logic [CH_W-1:0]     amem_ch_o,
  output logic                adc_start_o,
  output logic                capture_last_o,
  output logic                readout_last_o,
  output logic                ram_we_o,
  output logic [IDX_W-1:0]    ram_waddr_o,
  output logic [SAMPLE_W-1:0] ram_wdata_o
);

  logic              in_cap;
  logic              in_rd;
  logic [CELL_W-1:0] cell_q;
  logic [IDX_W-1:0]  idx_q;
  logic              wait_q;
  logic              take;
  logic              idx_end;

  assign in_cap = (phase_i == PH_CAPTURE);
  assign in_rd  = (phase_i == PH_READOUT);

  // Capture window: one analog cell per clock.
  assign capture_last_o = in_cap && (cell_q == CELL_W'(CELLS - 1));

  // Readout: start a conversion, then hold until the converter answers.
  assign take    = in_rd && wait_q && adc_done_i;
  assign idx_end = (idx_q == IDX_W'(TOTAL - 1));
  assign readout_last_o = take && idx_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_q <= '0;
      idx_q  <= '0;
      wait_q <= 1'b0;
    end else begin
      cell_q <= (in_cap && !capture_last_o) ? cell_q + 1'b1 : '0;
      if (!in_rd) begin
        idx_q  <= '0;
        wait_q <= 1'b0;
      end else if (!wait_q) begin
        wait_q <= 1'b1;
      end else if (adc_done_i) begin
        wait_q <= 1'b0;
        if (!idx_end) idx_q <= idx_q + 1'b1;
      end
    end
  end

  assign amem_wr_o   = in_cap;
  assign amem_rd_o   = in_rd;
  assign adc_start_o = in_rd && !wait_q;
  assign amem_addr_o = in_cap ? cell_q : (in_rd ? idx_q[CELL_W-1:0] : '0);
  assign amem_ch_o   = in_rd ? CH_W'(idx_q >> CELL_W) : '0;

  // Sample index already equals channel*CELLS + cell.
  assign ram_we_o    = take;
  assign ram_waddr_o = idx_q;
  assign ram_wdata_o = adc_data_i;

endmodule

// File: rtl/seq_sample_ram.sv
module seq_sample_ram #(
  parameter int DEPTH  = 768,
  parameter int DATA_W = 14,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [AW-1:0]     waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [AW-1:0]     raddr_i,
  output logic [DATA_W-1:0] rdata_o
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/seq_dump_stream.sv
module seq_dump_stream
  import seq_pkg::*;
#(
  parameter int TOTAL  = 768,
  parameter int DATA_W = 14,
  localparam int AW    = $clog2(TOTAL)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase_i,
  input  logic [DATA_W-1:0] ram_rdata_i,
  output logic [AW-1:0]     ram_raddr_o,
  input  logic              out_ready_i,
  output logic              out_valid_o,
  output logic [DATA_W-1:0] out_data_o,
  output logic              out_last_o,
  output logic              dump_last_o
);

  logic          in_dump;
  logic          fire;
  logic          at_end;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;

  assign in_dump = (phase_i == PH_DUMP);
  assign fire    = in_dump && out_ready_i;
  assign at_end  = (ptr_q == AW'(TOTAL - 1));

  // Read address runs one step ahead so the RAM output register always
  // holds the word at ptr_q; the first word is fetched while notifying.
  always_comb begin
    if (phase_i == PH_NOTIFY)       ptr_d = '0;
    else if (fire && !at_end)       ptr_d = ptr_q + 1'b1;
    else                            ptr_d = ptr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ram_raddr_o = ptr_d;
  assign out_valid_o = in_dump;
  assign out_data_o  = in_dump ? ram_rdata_i : '0;
  assign out_last_o  = in_dump && at_end;
  assign dump_last_o = fire && at_end;

endmodule

// File: rtl/capture_sequencer.sv
module capture_sequencer
  import seq_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int CELLS    = 256,
  parameter int SAMPLE_W = 14,
  localparam int CELL_W  = $clog2(CELLS),
  localparam int TOTAL   = NUM_CH * CELLS,
  localparam int IDX_W   = $clog2(TOTAL),
  localparam int CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trig_i,
  output logic                amem_wr_o,
  output logic                amem_rd_o,
  output logic [CELL_W-1:0]   amem_addr_o,
  output logic [CH_W-1:0]     amem_ch_o,
  output logic                adc_start_o,
  input  logic                adc_done_i,
  input  logic [SAMPLE_W-1:0] adc_data_i,
  output logic                irq_o,
  input  logic                host_rd_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [SAMPLE_W-1:0] out_data_o,
  output logic                out_last_o
);

  phase_e              phase;
  logic                capture_last;
  logic                readout_last;
  logic                dump_last;
  logic                ram_we;
  logic [IDX_W-1:0]    ram_waddr;
  logic [SAMPLE_W-1:0] ram_wdata;
  logic [IDX_W-1:0]    ram_raddr;
  logic [SAMPLE_W-1:0] ram_rdata;

  seq_phase_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .trig_i         (trig_i),
    .capture_last_i (capture_last),
    .readout_last_i (readout_last),
    .host_rd_i      (host_rd_i),
    .dump_last_i    (dump_last),
    .phase_o        (phase)
  );

  seq_sample_engine #(
    .NUM_CH   (NUM_CH),
    .CELLS    (CELLS),
    .SAMPLE_W (SAMPLE_W)
  ) u_engine (
    .clk            (clk),
    .rst_n          (rst_n),
    .phase_i        (phase),
    .adc_done_i     (adc_done_i),
    .adc_data_i     (adc_data_i),
    .amem_wr_o      (amem_wr_o),
    .amem_rd_o      (amem_rd_o),
    .amem_addr_o    (amem_addr_o),
    .amem_ch_o      (amem_ch_o),
    .adc_start_o    (adc_start_o),
    .capture_last_o (capture_last),
    .readout_last_o (readout_last),
    .ram_we_o       (ram_we),
    .ram_waddr_o    (ram_waddr),
    .ram_wdata_o    (ram_wdata)
  );

  seq_sample_ram #(
    .DEPTH  (TOTAL),
    .DATA_W (SAMPLE_W)
  ) u_ram (
    .clk     (clk),
    .we_i    (ram_we),
    .waddr_i (ram_waddr),
    .wdata_i (ram_wdata),
    .raddr_i (ram_raddr),
    .rdata_o (ram_rdata)
  );

  seq_dump_stream #(
    .TOTAL  (TOTAL),
    .DATA_W (SAMPLE_W)
  ) u_dump (
    .clk         (clk),
    .rst_n       (rst_n),
    .phase_i     (phase),
    .ram_rdata_i (ram_rdata),
    .ram_raddr_o (ram_raddr),
    .out_ready_i (out_ready_i),
    .out_valid_o (out_valid_o),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o),
    .dump_last_o (dump_last)
  );

  assign irq_o = (phase == PH_NOTIFY);

endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
  parameter int NUM_CH   = 3,
  parameter int CELLS    = 256,
  parameter int SAMPLE_W = 14,
  localparam int CELL_W  = $clog2(CELLS),
  localparam int TOTAL   = NUM_CH * CELLS,
  localparam int CNT_W   = $clog2(TOTAL) + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                trig_i,
  input logic                amem_wr_o,
  input logic                amem_rd_o,
  input logic [CELL_W-1:0]   amem_addr_o,
  input logic                adc_start_o,
  input logic                irq_o,
  input logic                host_rd_i,
  input logic                out_valid_o,
  input logic                out_ready_i,
  input logic [SAMPLE_W-1:0] out_data_o,
  input logic                out_last_o
);

  logic [CNT_W-1:0] beats_q;
  logic             fire;

  assign fire = out_valid_o && out_ready_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  beats_q <= '0;
    else if (fire && out_last_o) beats_q <= '0;
    else if (fire)               beats_q <= beats_q + 1'b1;
  end

  // R2: capture only opens after a trigger
  a_r2_wr_after_trig: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(amem_wr_o) |-> $past(trig_i));

  // R2: capture address advances one cell per clock
  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (amem_wr_o && $past(amem_wr_o)) |-> (amem_addr_o == $past(amem_addr_o) + 1'b1));

  // R4: phases are mutually exclusive at the pins
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({amem_wr_o, amem_rd_o, irq_o, out_valid_o}));

  // R5: convert start is a single-cycle pulse inside readout
  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |=> !adc_start_o);

  a_r5_start_in_readout: assert property (@(posedge clk) disable iff (!rst_n)
    adc_start_o |-> amem_rd_o);

  // R7: interrupt held until requested, then replaced by the dump
  a_r7_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !host_rd_i) |=> irq_o);

  a_r7_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && host_rd_i) |=> (!irq_o && out_valid_o));

  // R8: offered word frozen under back-pressure
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

  // R9: accepting the last word ends the dump
  a_r9_last_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last_o) |=> !out_valid_o);

  // R10: the last word is the TOTAL-th accepted word
  a_r10_count: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_last_o) |-> (beats_q == CNT_W'(TOTAL - 1)));

endmodule

bind capture_sequencer seq_checker #(
  .NUM_CH   (NUM_CH),
  .CELLS    (CELLS),
  .SAMPLE_W (SAMPLE_W)
) u_seq_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .trig_i      (trig_i),
  .amem_wr_o   (amem_wr_o),
  .amem_rd_o   (amem_rd_o),
  .amem_addr_o (amem_addr_o),
  .adc_start_o (adc_start_o),
  .irq_o       (irq_o),
  .host_rd_i   (host_rd_i),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_data_o  (out_data_o),
  .out_last_o  (out_last_o)
);

// File: tb/tb_capture_sequencer.sv
module tb_capture_sequencer;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH = 3;
  localparam int CELLS  = 256;
  localparam int TOTAL  = NUM_CH * CELLS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        trig = 1'b0;
  logic        adc_done = 1'b0;
  logic [13:0] adc_data = '0;
  logic        host_rd = 1'b0;
  logic        out_ready = 1'b0;

  logic        amem_wr_o, amem_rd_o, adc_start_o, irq_o;
  logic        out_valid_o, out_last_o;
  logic [7:0]  amem_addr_o;
  logic [1:0]  amem_ch_o;
  logic [13:0] out_data_o;

  int checks = 0;
  int fails  = 0;
  int run_no = 0;
  int ready_mode = 0;
  bit finished = 1'b0;

  // reference model state
  int m_ph = 0;  // 0 idle, 1 capture, 2 readout, 3 notify, 4 dump
  int m_cell = 0;
  int m_idx = 0;
  int m_wait = 0;
  int m_ptr = 0;

  capture_sequencer dut (
    .clk (clk), .rst_n (rst_n), .trig_i (trig),
    .amem_wr_o (amem_wr_o), .amem_rd_o (amem_rd_o),
    .amem_addr_o (amem_addr_o), .amem_ch_o (amem_ch_o),
    .adc_start_o (adc_start_o), .adc_done_i (adc_done), .adc_data_i (adc_data),
    .irq_o (irq_o), .host_rd_i (host_rd),
    .out_valid_o (out_valid_o), .out_ready_i (out_ready),
    .out_data_o (out_data_o), .out_last_o (out_last_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [13:0] adc_val(int r, int c, int k);
    return 14'((r * 1237 + c * 4099 + k * 53) & 16383);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference, advanced on each rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_cell = 0; m_idx = 0; m_wait = 0; m_ptr = 0;
    end else begin
      case (m_ph)
        0: if (trig) begin m_ph = 1; m_cell = 0; end
        1: if (m_cell == CELLS - 1) begin m_ph = 2; m_idx = 0; m_wait = 0; end
           else m_cell++;
        2: if (m_wait == 0) m_wait = 1;
           else if (adc_done) begin
             m_wait = 0;
             if (m_idx == TOTAL - 1) m_ph = 3; else m_idx++;
           end
        3: if (host_rd) begin m_ph = 4; m_ptr = 0; end
        4: if (out_ready) begin
             if (m_ptr == TOTAL - 1) m_ph = 0; else m_ptr++;
           end
        default: m_ph = 0;
      endcase
    end
  end

  // Compare every output against the model, away from the rising edge.
  always @(negedge clk) begin
    if (!finished) begin
      if (!rst_n) begin
        chk("R1", "reset wr", int'(amem_wr_o), 0);
        chk("R1", "reset valid", int'(out_valid_o), 0);
        chk("R1", "reset irq", int'(irq_o), 0);
      end else begin
        chk("R2", "amem_wr", int'(amem_wr_o), int'(m_ph == 1));
        chk("R4", "amem_rd", int'(amem_rd_o), int'(m_ph == 2));
        chk("R4", "amem_addr", int'(amem_addr_o),
            (m_ph == 1) ? m_cell : ((m_ph == 2) ? (m_idx % CELLS) : 0));
        chk("R4", "amem_ch", int'(amem_ch_o), (m_ph == 2) ? (m_idx / CELLS) : 0);
        chk("R5", "adc_start", int'(adc_start_o), int'(m_ph == 2 && m_wait == 0));
        chk("R7", "irq", int'(irq_o), int'(m_ph == 3));
        chk("R8", "out_valid", int'(out_valid_o), int'(m_ph == 4));
        chk("R6", "out_data", int'(out_data_o),
            (m_ph == 4) ? int'(adc_val(run_no, m_ptr / CELLS, m_ptr % CELLS)) : 0);
        chk("R9", "out_last", int'(out_last_o), int'(m_ph == 4 && m_ptr == TOTAL - 1));
      end
    end
  end

  // Converter model: one done per start after 1..3 cycles, plus stray
  // done pulses during capture and while the interrupt is pending.
  initial begin
    int seq = 0;
    int stray = 0;
    forever begin
      @(negedge clk);
      if (adc_start_o) begin
        logic [13:0] v;
        v = adc_val(run_no, int'(amem_ch_o), int'(amem_addr_o));
        seq++;
        repeat (1 + (seq % 3)) @(posedge clk);
        #1 adc_done = 1'b1; adc_data = v;
        @(posedge clk);
        #1 adc_done = 1'b0; adc_data = ~v;
      end else if ((amem_wr_o && amem_addr_o[5:0] == 6'd3) || (irq_o && stray < 2 + 2 * run_no)) begin
        if (irq_o) stray++;
        @(posedge clk);
        #1 adc_done = 1'b1; adc_data = 14'h2AAA;  // R5: must be ignored
        @(posedge clk);
        #1 adc_done = 1'b0;
      end
      if (!irq_o && !amem_wr_o && !amem_rd_o) stray = 0;
    end
  end

  // Stream sink with a per-run ready pattern.
  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      case (ready_mode)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 3) != 0;
        default: out_ready = (cyc % 7) >= 4;
      endcase
    end
  end

  task automatic pulse_trig();
    @(posedge clk); #1 trig = 1'b1;
    @(posedge clk); #1 trig = 1'b0;
  endtask

  task automatic pulse_host();
    @(posedge clk); #1 host_rd = 1'b1;
    @(posedge clk); #1 host_rd = 1'b0;
  endtask

  task automatic finish_up();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    for (int r = 0; r < 3; r++) begin
      run_no = r;
      ready_mode = r;
      repeat (4) @(posedge clk);
      pulse_trig();                         // R2 / R10 start
      repeat (20) @(posedge clk);
      pulse_trig();                         // R3: stray trigger in capture
      pulse_host();                         // R7: stray request in capture
      do @(negedge clk); while (!amem_rd_o);
      repeat (37) @(posedge clk);
      pulse_trig();                         // R3: stray trigger in readout
      pulse_host();                         // R7: stray request in readout
      do @(negedge clk); while (!irq_o);
      repeat (5 + 9 * r) @(posedge clk);    // R7: interrupt must persist
      pulse_trig();                         // R3: stray trigger while notifying
      pulse_host();                         // R8 dump begins
      pulse_trig();                         // R3: stray trigger in dump
      do @(negedge clk); while (out_valid_o);
      chk("R9", "idle after last", int'(irq_o | amem_wr_o | amem_rd_o), 0);
    end
    repeat (5) @(posedge clk);
    finish_up();
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

endmodule